// File: doc/BRIEF.md
# Multiple-Register Transfer Issue Sequencer

This block runs a load-multiple or store-multiple operation for the integer register file. A one-cycle start request carries a direction bit, a byte base address and a register mask. The sequencer accepts the request when it is idle. It spends one overhead cycle, then moves one selected register per cycle between memory and the register file, then spends a closing overhead cycle. Registers go in ascending number order, at consecutive word addresses. The memory is treated as always hitting. Read data comes back in the same cycle as the request, so each transfer is complete within its own cycle.

For the whole operation the issue stage is held busy. The stall output towards the next instruction is raised whether or not that instruction uses any of the registers. The number of cycles the operation occupies is 2 plus the number of mask bits set. It is reported on an output from the cycle after acceptance. With the default of 16 registers this gives 2 to 18 cycles, and setting `NREG` to 18 gives 2 to 20.

Top module: `mrt_issue_seq`

## Requirements
- R1: After a start is accepted at a clock edge, `busy_o` is high for exactly 2 + popcount(mask) consecutive cycles beginning with the next cycle. `done_o` is high only in the last of those cycles.
- R2: From the cycle after acceptance, `cycles_o` equals 2 + popcount(mask). It holds that value until the next accepted start.
- R3: Selected registers are transferred in ascending index order, one per cycle. The transfer of the k-th selected register (k from 0) occurs in busy cycle k+1, where busy cycle 0 is the first busy cycle. No transfer occurs in busy cycle 0 or in the last busy cycle.
- R4: The k-th transfer uses the byte address base + 4·k.
- R5: A load (`is_load_i`=1) drives `mem_we_o`=0 and `rf_we_o`=1, with `rf_waddr_o` equal to the register index. In the same cycle, `rf_wdata_o` equals `mem_rdata_i`.
- R6: A store (`is_load_i`=0) drives `mem_we_o`=1 and `rf_we_o`=0, with `rf_raddr_o` equal to the register index. In the same cycle, `mem_wdata_o` equals `rf_rdata_i`.
- R7: An all-zero mask gives a 2-cycle operation with no memory request.
- R8: `stall_o` is high in the cycle a start is presented to an idle block and in every busy cycle, for any mask and direction. It is low when the block is idle and no start is presented.
- R9: A start presented while `busy_o` is high is ignored. The running operation's cycle count, addresses, register order and direction are unchanged, and no extra operation follows.
- R10: While reset is high and after it, the block is idle: `busy_o`, `done_o`, `stall_o` (with no start), `mem_req_o` and `rf_we_o` are 0 and `cycles_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| is_load_i | input | 1 | 1 = load registers from memory, 0 = store them |
| base_addr_i | input | AW | Byte address of the first word |
| reg_mask_i | input | NREG | One bit per register to transfer |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, same cycle |
| rf_raddr_o | output | IW | Register-file read index |
| rf_rdata_i | input | DW | Register-file read data, same cycle |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | IW | Register-file write index |
| rf_wdata_o | output | DW | Register-file write data |
| busy_o | output | 1 | Operation in progress |
| stall_o | output | 1 | Hold the following instruction |
| done_o | output | 1 | Last cycle of the operation |
| cycles_o | output | CW | Cycles the current or last operation occupies |

## Verification
The bench goes after the empty mask. A design that dropped the overhead there would finish in fewer than two cycles, or would issue a stray access to the base address. The full mask and the single top or bottom bit probe the lowest-bit picker and the end-of-list detection. An off-by-one in either shows up as a skipped register, a repeated one, or a closing cycle that is missing or doubled. A start pushed in mid-operation, with a different mask and direction, catches a sequencer that restarts or merges requests. Random masks in both directions compare the cycle count, the order, the addresses and the data paths against a count of mask bits.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    // Phase of one multi-register operation.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HEAD = 2'd1,
        PH_XFER = 2'd2,
        PH_TAIL = 2'd3
    } mrt_phase_e;

    // Fixed overhead cycles wrapped around the per-register transfers.
    localparam int unsigned OVERHEAD_CYCLES = 2;

    // Control bundle latched at acceptance.
    typedef struct packed {
        logic is_load;
        logic active;
    } mrt_ctl_t;

endpackage

// File: rtl/mrt_pick_lowest.sv
module mrt_pick_lowest #(
    parameter int unsigned NREG = 16,
    localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [NREG-1:0] mask_i,
    output logic [NREG-1:0] onehot_o,
    output logic [IW-1:0]   idx_o,
    output logic            any_o
);

    // below[i] is set when some bit under position i is set.
    logic [NREG:0] below;
    assign below[0] = 1'b0;

    for (genvar i = 0; i < NREG; i++) begin : g_chain
        assign below[i+1]  = below[i] | mask_i[i];
        assign onehot_o[i] = mask_i[i] & ~below[i];
    end

    assign any_o = below[NREG];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (onehot_o[i]) idx_o = idx_o | IW'(i);
        end
    end

endmodule

// File: rtl/mrt_seq_fsm.sv
module mrt_seq_fsm
    import mrt_pkg::*;
#(
    parameter int unsigned NREG = 16,
    parameter int unsigned AW   = 32,
    parameter int unsigned BPW  = 4,
    localparam int unsigned CW  = $clog2(NREG + OVERHEAD_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            is_load_i,
    input  logic [AW-1:0]   base_i,
    input  logic [NREG-1:0] mask_i,
    input  logic [NREG-1:0] pick_onehot_i,
    output mrt_phase_e      phase_o,
    output logic [NREG-1:0] left_o,
    output logic [AW-1:0]   addr_o,
    output mrt_ctl_t        ctl_o,
    output logic [CW-1:0]   cycles_o
);

    mrt_phase_e      phase_q;
    logic [NREG-1:0] left_q;
    logic [AW-1:0]   addr_q;
    mrt_ctl_t        ctl_q;
    logic [CW-1:0]   cyc_q;
    logic [CW-1:0]   occ_q;

    logic            accept;
    logic [CW-1:0]   cyc_new;
    logic [NREG-1:0] left_nxt;

    assign accept   = start_i && (phase_q == PH_IDLE);
    assign left_nxt = left_q & ~pick_onehot_i;

    always_comb begin
        cyc_new = CW'(OVERHEAD_CYCLES);
        for (int i = 0; i < NREG; i++) cyc_new = cyc_new + CW'(mask_i[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            left_q  <= '0;
            addr_q  <= '0;
            ctl_q   <= '0;
            cyc_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (accept) begin
                    phase_q       <= PH_HEAD;
                    left_q        <= mask_i;
                    addr_q        <= base_i;
                    ctl_q.is_load <= is_load_i;
                    ctl_q.active  <= 1'b1;
                    cyc_q         <= cyc_new;
                end
                PH_HEAD: phase_q <= (left_q != '0) ? PH_XFER : PH_TAIL;
                PH_XFER: begin
                    left_q <= left_nxt;
                    addr_q <= addr_q + AW'(BPW);
                    if (left_nxt == '0) phase_q <= PH_TAIL;
                end
                PH_TAIL: begin
                    phase_q      <= PH_IDLE;
                    ctl_q.active <= 1'b0;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Occupancy counter used only by the checks below.
    always_ff @(posedge clk) begin
        if (rst)                   occ_q <= '0;
        else if (accept)           occ_q <= '0;
        else if (phase_q != PH_IDLE) occ_q <= occ_q + 1'b1;
    end

    assign phase_o  = phase_q;
    assign left_o   = left_q;
    assign addr_o   = addr_q;
    assign ctl_o    = ctl_q;
    assign cycles_o = cyc_q;

    a_r1_len_matches: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TAIL) |-> (occ_q == cyc_q - 1'b1));
    a_r1_done_then_idle: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TAIL) |=> (phase_q == PH_IDLE));
    a_r9_count_stable: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |=> $stable(cyc_q));
    a_r7_empty_skips: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HEAD && left_q == '0) |=> (phase_q == PH_TAIL));

endmodule

// File: rtl/mrt_issue_seq.sv
module mrt_issue_seq
    import mrt_pkg::*;
#(
    parameter int unsigned NREG = 16,
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32,
    localparam int unsigned BPW = DW / 8,
    localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int unsigned CW  = $clog2(NREG + OVERHEAD_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            is_load_i,
    input  logic [AW-1:0]   base_addr_i,
    input  logic [NREG-1:0] reg_mask_i,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic [IW-1:0]   rf_raddr_o,
    input  logic [DW-1:0]   rf_rdata_i,
    output logic            rf_we_o,
    output logic [IW-1:0]   rf_waddr_o,
    output logic [DW-1:0]   rf_wdata_o,
    output logic            busy_o,
    output logic            stall_o,
    output logic            done_o,
    output logic [CW-1:0]   cycles_o
);

    mrt_phase_e      phase;
    logic [NREG-1:0] left;
    logic [NREG-1:0] onehot;
    logic [IW-1:0]   idx;
    logic            any;
    logic [AW-1:0]   addr;
    mrt_ctl_t        ctl;
    logic            xfer;

    mrt_pick_lowest #(.NREG(NREG)) u_pick (
        .mask_i   (left),
        .onehot_o (onehot),
        .idx_o    (idx),
        .any_o    (any)
    );

    mrt_seq_fsm #(.NREG(NREG), .AW(AW), .BPW(BPW)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .is_load_i     (is_load_i),
        .base_i        (base_addr_i),
        .mask_i        (reg_mask_i),
        .pick_onehot_i (onehot),
        .phase_o       (phase),
        .left_o        (left),
        .addr_o        (addr),
        .ctl_o         (ctl),
        .cycles_o      (cycles_o)
    );

    assign xfer        = (phase == PH_XFER) && any;
    assign mem_req_o   = xfer;
    assign mem_we_o    = xfer && !ctl.is_load;
    assign mem_addr_o  = addr;
    assign mem_wdata_o = rf_rdata_i;
    assign rf_raddr_o  = idx;
    assign rf_we_o     = xfer && ctl.is_load;
    assign rf_waddr_o  = idx;
    assign rf_wdata_o  = mem_rdata_i;
    assign busy_o      = (phase != PH_IDLE);
    assign done_o      = (phase == PH_TAIL);
    assign stall_o     = busy_o || start_i;

    a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && $past(mem_req_o)) |-> (rf_raddr_o > $past(rf_raddr_o)));
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(BPW)));
    a_r5_one_direction: assert property (@(posedge clk) disable iff (rst)
        !(rf_we_o && mem_we_o));
    a_r8_stall_covers_busy: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> stall_o);
    a_r3_req_inside_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> (busy_o && !done_o));

endmodule

// File: tb/mrt_issue_seq_tb_top.sv
`timescale 1ns/1ps
module mrt_issue_seq_tb_top;

    localparam int NREG = 16;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int IW   = 4;
    localparam int CW   = $clog2(NREG + 3);

    logic            clk = 1'b0;
    logic            rst;
    logic            start_i;
    logic            is_load_i;
    logic [AW-1:0]   base_addr_i;
    logic [NREG-1:0] reg_mask_i;
    logic            mem_req_o, mem_we_o;
    logic [AW-1:0]   mem_addr_o;
    logic [DW-1:0]   mem_wdata_o, mem_rdata_i;
    logic [IW-1:0]   rf_raddr_o, rf_waddr_o;
    logic [DW-1:0]   rf_rdata_i, rf_wdata_o;
    logic            rf_we_o, busy_o, stall_o, done_o;
    logic [CW-1:0]   cycles_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] mem_model(logic [AW-1:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0000_5A5A;
    endfunction
    function automatic logic [DW-1:0] rf_model(logic [IW-1:0] r);
        return {8'hC0, 20'h0, r} ^ 32'h1234_0000;
    endfunction
    function automatic int popc(logic [NREG-1:0] m);
        int c = 0;
        for (int i = 0; i < NREG; i++) c += int'(m[i]);
        return c;
    endfunction
    function automatic int nth_set(logic [NREG-1:0] m, int k);
        int seen = 0;
        for (int i = 0; i < NREG; i++) begin
            if (m[i]) begin
                if (seen == k) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    assign mem_rdata_i = mem_model(mem_addr_o);
    assign rf_rdata_i  = rf_model(rf_raddr_o);

    mrt_issue_seq #(.NREG(NREG), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .is_load_i(is_load_i),
        .base_addr_i(base_addr_i), .reg_mask_i(reg_mask_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .busy_o(busy_o), .stall_o(stall_o), .done_o(done_o), .cycles_o(cycles_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input bit ld, input logic [AW-1:0] base,
                          input logic [NREG-1:0] mask, input bit inject);
        int exp_len  = 2 + popc(mask);
        int n_busy   = 0;
        int k        = 0;
        int done_at  = -1;
        int n_done   = 0;
        bit order_ok = 1, addr_ok = 1, data_ok = 1, slot_ok = 1, stall_ok = 1, cyc_ok = 1;
        @(negedge clk);
        start_i = 1'b1; is_load_i = ld; base_addr_i = base; reg_mask_i = mask;
        #1;
        chk(stall_o == 1'b1, "R8", "stall in accept cycle", stall_o, 1);
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (!busy_o) break;
            n_busy++;
            if (!stall_o) stall_ok = 0;
            if (cycles_o != CW'(exp_len)) cyc_ok = 0;
            if (done_o) begin done_at = c; n_done++; end
            if (mem_req_o) begin
                int r = nth_set(mask, k);
                if (c != k + 1) slot_ok = 0;
                if (ld) begin
                    if (int'(rf_waddr_o) != r) order_ok = 0;
                    if (mem_we_o || !rf_we_o || rf_wdata_o != mem_model(mem_addr_o)) data_ok = 0;
                end else begin
                    if (int'(rf_raddr_o) != r) order_ok = 0;
                    if (!mem_we_o || rf_we_o || mem_wdata_o != rf_model(IW'(r))) data_ok = 0;
                end
                if (mem_addr_o != base + AW'(4 * k)) addr_ok = 0;
                k++;
            end
            if (inject && c == 0) begin
                start_i = 1'b1; is_load_i = ~ld; reg_mask_i = ~mask;
                base_addr_i = base ^ 32'h0000_1000;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(n_busy == exp_len, inject ? "R9" : "R1", "busy length", n_busy, exp_len);
        chk(n_done == 1 && done_at == exp_len - 1, "R1", "done position", done_at, exp_len - 1);
        chk(cyc_ok && cycles_o == CW'(exp_len), "R2", "cycles_o", cycles_o, exp_len);
        chk(k == popc(mask), mask == '0 ? "R7" : "R3", "transfer count", k, popc(mask));
        chk(order_ok && slot_ok, "R3", "ascending order and slot", order_ok, 1);
        chk(addr_ok, "R4", "word addresses", addr_ok, 1);
        chk(data_ok, ld ? "R5" : "R6", "data path", data_ok, 1);
        chk(stall_ok && stall_o == 1'b0, "R8", "stall while busy, low after", stall_o, 0);
        if (inject)
            chk(busy_o == 1'b0 && n_busy == exp_len, "R9", "no extra operation", busy_o, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7031));
        rst = 1'b1; start_i = 1'b0; is_load_i = 1'b0; base_addr_i = '0; reg_mask_i = '0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !stall_o && !mem_req_o && !rf_we_o && cycles_o == 0,
            "R10", "state in reset", {busy_o, done_o, stall_o, mem_req_o, rf_we_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && !stall_o && cycles_o == 0, "R10", "idle after reset",
            {busy_o, stall_o}, 0);

        run_op(1'b1, 32'h0000_1000, 16'h0000, 1'b0);   // R7 empty load
        run_op(1'b0, 32'h0000_2000, 16'h0000, 1'b0);   // R7 empty store
        run_op(1'b1, 32'h0000_3000, 16'hFFFF, 1'b0);   // full list
        run_op(1'b0, 32'h0000_4000, 16'hFFFF, 1'b0);
        run_op(1'b1, 32'h0000_5000, 16'h0001, 1'b0);   // lowest only
        run_op(1'b0, 32'h0000_6000, 16'h8000, 1'b0);   // highest only
        run_op(1'b1, 32'h0000_7000, 16'h8421, 1'b1);   // R9 start while busy
        run_op(1'b0, 32'h0000_8000, 16'h0000, 1'b1);   // R9 during empty op
        for (int i = 0; i < 60; i++) begin
            logic [NREG-1:0] m = NREG'($urandom);
            logic [AW-1:0]   b = {$urandom} & 32'hFFFF_FFFC;
            run_op(1'($urandom), b, m, (i % 7) == 3);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule